// File: doc/BRIEF.md
# Network Interrupt Status and Mask Unit

This unit gathers single-cycle event pulses from a network controller's receive, transmit and remote-transfer paths into a sticky 8-bit status word. It also watches the three 8-bit statistics tallies. Seven enable bits select which of the sticky status bits may raise the one interrupt line. The host reads the status word and acknowledges events by writing ones to the bits it has handled.

The top bit of the status word is read-only. It shows that the controller is stopped. It is set when a stop command actually takes effect, which happens only once the frame in flight has finished. It is also set when the receive ring is overrun. A start command clears it, and so does the removal of a frame from the ring. The unit powers up in the stopped state.

Top module: `net_irq_unit`

## Requirements
- R1: During and right after reset, status_o reads 0x80, mask_o reads 0x00 and irq_o is low.
- R2: A pulse on an event input sets its status bit at the next clock edge. The bit positions are: received OK = bit 0, transmitted OK = bit 1, receive error = bit 2, transmit error = bit 3, ring overwrite = bit 4, remote transfer done = bit 6.
- R3: Status bits 0 to 6 hold their value until the host writes with host_we=1 and host_sel=0, carrying a 1 in that bit of host_wdata. Writing a 0 to a bit leaves it unchanged.
- R4: If an event and a host clear hit the same status bit in the same cycle, the bit stays set.
- R5: Status bit 5 is set when the MSB of any of the tally counters (packed in tally_i, counter k in bits 8k+7..8k) changes from 0 to 1 between two consecutive clock samples. An MSB that simply stays at 1 does not set the bit again.
- R6: A host write with host_sel=1 loads host_wdata[6:0] into the mask. mask_o[7] always reads 0.
- R7: irq_o is registered. In each cycle it equals the OR, over bits 0 to 6, of status AND mask as they stood one cycle earlier. Status bit 7 never drives irq_o.
- R8: Host writes to status bit 7 have no effect.
- R9: A stop command issued while frame_busy is low sets status bit 7 at the next edge. While frame_busy is high, the stop waits. Bit 7 is set at the edge that closes the first cycle in which frame_busy is low.
- R10: A start command clears status bit 7 and cancels any pending stop. If start and stop arrive in the same cycle, start wins.
- R11: A ring overwrite sets status bit 7 as well as bit 4. A frame_removed pulse clears bit 7. When a set condition and a clear condition occur in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert, released synchronously |
| ev_rx_ok | input | 1 | Frame received without error (pulse) |
| ev_tx_ok | input | 1 | Frame transmitted without error (pulse) |
| ev_rx_err | input | 1 | Receive error (pulse) |
| ev_tx_err | input | 1 | Transmit error (pulse) |
| ev_ring_ovw | input | 1 | Receive ring overwrite (pulse) |
| ev_xfer_done | input | 1 | Remote transfer complete (pulse) |
| tally_i | input | NUM_TALLY*TALLY_W | Packed statistics tally counters |
| cmd_start | input | 1 | Start command (pulse) |
| cmd_stop | input | 1 | Stop command (pulse) |
| frame_busy | input | 1 | A frame is in progress |
| frame_removed | input | 1 | At least one frame taken out of the ring (pulse) |
| host_we | input | 1 | Host write strobe |
| host_sel | input | 1 | 0 = status (write-one-to-clear), 1 = mask |
| host_wdata | input | 8 | Host write data |
| status_o | output | 8 | Status word, bit 7 = stopped |
| mask_o | output | 8 | Enable mask, bit 7 reads 0 |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The bench uses the default parameters: three tally counters, each 8 bits wide. The tallies are driven directly, so each MSB can be walked across its 0x7F to 0x80 boundary, held at 1 after a clear, and made to rise on two counters at once. The bench holds frame_busy high for several cycles around a stop command, and it lines up start, stop, overwrite and frame-removal pulses in the same cycle. These cases expose the deferred stop and the set-over-clear priority of the stopped bit. A long stretch of mixed random traffic then exercises every mask combination against the registered interrupt.

// File: rtl/nirq_pkg.sv
package nirq_pkg;
  localparam int STAT_W   = 8;
  localparam int STICKY_W = 7;

  localparam int B_RXOK  = 0;
  localparam int B_TXOK  = 1;
  localparam int B_RXERR = 2;
  localparam int B_TXERR = 3;
  localparam int B_OVW   = 4;
  localparam int B_CNT   = 5;
  localparam int B_XFER  = 6;
  localparam int B_STOP  = 7;

  typedef enum logic {
    SEL_STATUS = 1'b0,
    SEL_MASK   = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/nirq_tally_watch.sv
module nirq_tally_watch #(
  parameter int NUM_TALLY = 3,
  parameter int TALLY_W   = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NUM_TALLY*TALLY_W-1:0] tally_i,
  output logic                         ovf_o
);
  localparam int MSB_OFS = TALLY_W - 1;

  logic [NUM_TALLY-1:0] msb_now;
  logic [NUM_TALLY-1:0] msb_q;
  logic [NUM_TALLY-1:0] msb_d;

  for (genvar g = 0; g < NUM_TALLY; g++) begin : g_msb
    assign msb_now[g] = tally_i[g*TALLY_W + MSB_OFS];
  end

  always_comb begin
    msb_d = msb_now;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) msb_q <= '0;
    else        msb_q <= msb_d;
  end

  assign ovf_o = |(msb_now & ~msb_q);
endmodule

// File: rtl/nirq_run_state.sv
module nirq_run_state (
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_start,
  input  logic cmd_stop,
  input  logic frame_busy,
  input  logic ovw_evt,
  input  logic frame_removed,
  output logic stopped_o
);
  logic pend_q, pend_d;
  logic stop_q, stop_d;
  logic req, take, set_c, clr_c, stop_en;

  always_comb begin
    req     = pend_q | cmd_stop;
    take    = req & ~frame_busy & ~cmd_start;
    pend_d  = req & frame_busy & ~cmd_start;
    set_c   = take | ovw_evt;
    clr_c   = cmd_start | frame_removed;
    stop_en = set_c | clr_c;
    stop_d  = set_c;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      stop_q <= 1'b1;
    end else begin
      pend_q <= pend_d;
      if (stop_en) stop_q <= stop_d;
    end
  end

  assign stopped_o = stop_q;
endmodule

// File: rtl/nirq_status_bank.sv
module nirq_status_bank #(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] evt_i,
  input  logic         clr_we,
  input  logic [W-1:0] clr_bits,
  output logic [W-1:0] stat_o
);
  logic [W-1:0] st_q;
  logic [W-1:0] st_d;
  logic [W-1:0] st_en;

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_comb begin
      st_en[i] = evt_i[i] | (clr_we & clr_bits[i]);
      st_d[i]  = evt_i[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        st_q[i] <= 1'b0;
      else if (st_en[i]) st_q[i] <= st_d[i];
    end
  end

  assign stat_o = st_q;
endmodule

// File: rtl/nirq_mask_irq.sv
module nirq_mask_irq #(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         mask_we,
  input  logic [W-1:0] mask_wdata,
  input  logic [W-1:0] stat_i,
  output logic [W-1:0] mask_o,
  output logic         irq_o
);
  logic [W-1:0] mask_q;
  logic         irq_q, irq_d;

  always_comb begin
    irq_d = |(stat_i & mask_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      if (mask_we) mask_q <= mask_wdata;
      irq_q <= irq_d;
    end
  end

  assign mask_o = mask_q;
  assign irq_o  = irq_q;
endmodule

// File: rtl/net_irq_unit.sv
module net_irq_unit
  import nirq_pkg::*;
#(
  parameter int NUM_TALLY = 3,
  parameter int TALLY_W   = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         ev_rx_ok,
  input  logic                         ev_tx_ok,
  input  logic                         ev_rx_err,
  input  logic                         ev_tx_err,
  input  logic                         ev_ring_ovw,
  input  logic                         ev_xfer_done,
  input  logic [NUM_TALLY*TALLY_W-1:0] tally_i,
  input  logic                         cmd_start,
  input  logic                         cmd_stop,
  input  logic                         frame_busy,
  input  logic                         frame_removed,
  input  logic                         host_we,
  input  logic                         host_sel,
  input  logic [7:0]                   host_wdata,
  output logic [7:0]                   status_o,
  output logic [7:0]                   mask_o,
  output logic                         irq_o
);
  logic                cnt_ovf;
  logic [STICKY_W-1:0] evt_vec;
  logic [STICKY_W-1:0] sticky;
  logic [STICKY_W-1:0] mask_v;
  logic                stopped;
  logic                wr_status, wr_mask;
  reg_sel_e            sel;
  logic                unused_wd7;

  assign sel        = reg_sel_e'(host_sel);
  assign wr_status  = host_we & (sel == SEL_STATUS);
  assign wr_mask    = host_we & (sel == SEL_MASK);
  assign unused_wd7 = host_wdata[B_STOP];

  always_comb begin
    evt_vec          = '0;
    evt_vec[B_RXOK]  = ev_rx_ok;
    evt_vec[B_TXOK]  = ev_tx_ok;
    evt_vec[B_RXERR] = ev_rx_err;
    evt_vec[B_TXERR] = ev_tx_err;
    evt_vec[B_OVW]   = ev_ring_ovw;
    evt_vec[B_CNT]   = cnt_ovf;
    evt_vec[B_XFER]  = ev_xfer_done;
  end

  nirq_tally_watch #(.NUM_TALLY(NUM_TALLY), .TALLY_W(TALLY_W)) u_tally (
    .clk(clk), .rst_n(rst_n), .tally_i(tally_i), .ovf_o(cnt_ovf)
  );

  nirq_status_bank #(.W(STICKY_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_vec), .clr_we(wr_status),
    .clr_bits(host_wdata[STICKY_W-1:0]), .stat_o(sticky)
  );

  nirq_run_state u_run (
    .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_stop(cmd_stop),
    .frame_busy(frame_busy), .ovw_evt(ev_ring_ovw),
    .frame_removed(frame_removed), .stopped_o(stopped)
  );

  nirq_mask_irq #(.W(STICKY_W)) u_irq (
    .clk(clk), .rst_n(rst_n), .mask_we(wr_mask),
    .mask_wdata(host_wdata[STICKY_W-1:0]), .stat_i(sticky),
    .mask_o(mask_v), .irq_o(irq_o)
  );

  assign status_o = {stopped, sticky};
  assign mask_o   = {1'b0, mask_v};
endmodule

// File: rtl/net_irq_unit_chk.sv
module net_irq_unit_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ev_rx_ok,
  input logic       ev_tx_err,
  input logic       ev_ring_ovw,
  input logic       cmd_start,
  input logic       frame_busy,
  input logic       host_we,
  input logic       host_sel,
  input logic [7:0] host_wdata,
  input logic [7:0] status_o,
  input logic [7:0] mask_o,
  input logic       irq_o
);
  logic clr0;
  assign clr0 = host_we && !host_sel && host_wdata[0];

  a_r2_rxok_sets: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rx_ok |=> status_o[0]);
  a_r2_txerr_sets: assert property (@(posedge clk) disable iff (!rst_n)
    ev_tx_err |=> status_o[3]);
  a_r3_w1c: assert property (@(posedge clk) disable iff (!rst_n)
    (clr0 && !ev_rx_ok) |=> !status_o[0]);
  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o[0] && !clr0) |=> status_o[0]);
  a_r7_irq: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_o == $past(|(status_o[6:0] & mask_o[6:0]))));
  a_r9_busy_defers: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_busy && !ev_ring_ovw && !status_o[7]) |=> !status_o[7]);
  a_r10_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_start && !ev_ring_ovw) |=> !status_o[7]);
  a_r11_ovw_sets: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ring_ovw |=> (status_o[7] && status_o[4]));
endmodule

bind net_irq_unit net_irq_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ev_rx_ok(ev_rx_ok), .ev_tx_err(ev_tx_err),
  .ev_ring_ovw(ev_ring_ovw), .cmd_start(cmd_start), .frame_busy(frame_busy),
  .host_we(host_we), .host_sel(host_sel), .host_wdata(host_wdata),
  .status_o(status_o), .mask_o(mask_o), .irq_o(irq_o)
);

// File: tb/test_net_irq_unit.sv
`timescale 1ns/1ps
module test_net_irq_unit;
  localparam int NT = 3;
  localparam int TW = 8;
  localparam int WD_CYCLES = 20000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ev_rx_ok = 0, ev_tx_ok = 0, ev_rx_err = 0, ev_tx_err = 0;
  logic ev_ring_ovw = 0, ev_xfer_done = 0;
  logic [NT*TW-1:0] tally = '0;
  logic cmd_start = 0, cmd_stop = 0, frame_busy = 0, frame_removed = 0;
  logic host_we = 0, host_sel = 0;
  logic [7:0] host_wdata = '0;
  logic [7:0] status_o, mask_o;
  logic irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  string phase = "R1";

  always #10 clk = ~clk;

  net_irq_unit #(.NUM_TALLY(NT), .TALLY_W(TW)) i_net_irq_unit (
    .clk(clk), .rst_n(rst_n), .ev_rx_ok(ev_rx_ok), .ev_tx_ok(ev_tx_ok),
    .ev_rx_err(ev_rx_err), .ev_tx_err(ev_tx_err), .ev_ring_ovw(ev_ring_ovw),
    .ev_xfer_done(ev_xfer_done), .tally_i(tally), .cmd_start(cmd_start),
    .cmd_stop(cmd_stop), .frame_busy(frame_busy), .frame_removed(frame_removed),
    .host_we(host_we), .host_sel(host_sel), .host_wdata(host_wdata),
    .status_o(status_o), .mask_o(mask_o), .irq_o(irq_o)
  );

  // behavioural reference
  bit [6:0] m_st, m_mask, m_evs;
  bit       m_stopped, m_pend, m_irq, m_irq_next, m_stop_now;
  bit [NT-1:0] m_prev;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_mask = 0; m_stopped = 1; m_pend = 0; m_irq = 0; m_prev = 0;
    end else begin
      m_irq_next = ((m_st & m_mask) != 0);
      m_evs = {ev_xfer_done, 1'b0, ev_ring_ovw, ev_tx_err, ev_rx_err, ev_tx_ok, ev_rx_ok};
      for (int k = 0; k < NT; k++) begin
        if (tally[k*TW+TW-1] && !m_prev[k]) m_evs[5] = 1;
        m_prev[k] = tally[k*TW+TW-1];
      end
      if (host_we && !host_sel) m_st = m_st & ~host_wdata[6:0];
      m_st = m_st | m_evs;
      if (host_we && host_sel) m_mask = host_wdata[6:0];
      m_stop_now = 0;
      if (cmd_start) m_pend = 0;
      else if (m_pend || cmd_stop) begin
        if (frame_busy) m_pend = 1;
        else begin m_pend = 0; m_stop_now = 1; end
      end
      if (m_stop_now || ev_ring_ovw) m_stopped = 1;
      else if (cmd_start || frame_removed) m_stopped = 0;
      m_irq = m_irq_next;
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk({phase, " status"}, {24'd0, status_o}, {24'd0, m_stopped, m_st});
      chk({phase, " mask"},   {24'd0, mask_o},   {25'd0, m_mask});
      chk({phase, " irq"},    {31'd0, irq_o},    {31'd0, m_irq});
    end
  end

  task automatic nxt(int n = 1);
    repeat (n) begin
      @(negedge clk); #1;
      ev_rx_ok = 0; ev_tx_ok = 0; ev_rx_err = 0; ev_tx_err = 0;
      ev_ring_ovw = 0; ev_xfer_done = 0; cmd_start = 0; cmd_stop = 0;
      frame_removed = 0; host_we = 0; host_sel = 0; host_wdata = 0;
    end
  endtask

  task automatic hwrite(bit sel, logic [7:0] d);
    host_we = 1; host_sel = sel; host_wdata = d; nxt();
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    nxt(3);
    phase = "R1";
    chk("R1 status in reset", {24'd0, status_o}, 32'h80);
    chk("R1 mask in reset",   {24'd0, mask_o},   32'h00);
    chk("R1 irq in reset",    {31'd0, irq_o},    32'h0);
    rst_n = 1; nxt(2);
    chk("R1 status after reset", {24'd0, status_o}, 32'h80);

    phase = "R2";
    ev_rx_ok = 1; nxt(); ev_tx_ok = 1; nxt(); ev_rx_err = 1; nxt();
    ev_tx_err = 1; nxt(); ev_xfer_done = 1; nxt(); ev_ring_ovw = 1; nxt(2);
    chk("R2 all events", {24'd0, status_o}, 32'hDF);

    phase = "R3";
    hwrite(0, 8'h00); nxt();
    chk("R3 write zero keeps", {24'd0, status_o}, 32'hDF);
    for (int b = 0; b < 7; b++) begin hwrite(0, 8'h01 << b); nxt(); end
    chk("R3 all cleared", {24'd0, status_o[6:0]}, 32'h0);

    phase = "R8";
    hwrite(0, 8'hFF); nxt();
    chk("R8 bit7 untouched", {31'd0, status_o[7]}, 32'h1);

    phase = "R4";
    ev_rx_err = 1; host_we = 1; host_sel = 0; host_wdata = 8'h04; nxt(2);
    chk("R4 event beats clear", {31'd0, status_o[2]}, 32'h1);

    phase = "R6";
    hwrite(1, 8'hFF); nxt();
    chk("R6 mask bit7 zero", {24'd0, mask_o}, 32'h7F);

    phase = "R7";
    hwrite(0, 8'h7F); nxt(2);
    chk("R7 irq low when clear", {31'd0, irq_o}, 32'h0);
    hwrite(1, 8'h02); ev_rx_ok = 1; nxt(3);
    chk("R7 masked event no irq", {31'd0, irq_o}, 32'h0);
    ev_tx_ok = 1; nxt(3);
    chk("R7 enabled event irq", {31'd0, irq_o}, 32'h1);
    hwrite(1, 8'h80); nxt(2);
    chk("R7 bit7 does not interrupt", {31'd0, irq_o}, 32'h0);
    hwrite(0, 8'h7F); nxt();

    phase = "R10";
    cmd_start = 1; nxt(2);
    chk("R10 start clears", {31'd0, status_o[7]}, 32'h0);

    phase = "R9";
    frame_busy = 1; cmd_stop = 1; nxt(5);
    chk("R9 stop deferred", {31'd0, status_o[7]}, 32'h0);
    frame_busy = 0; nxt(2);
    chk("R9 stop taken", {31'd0, status_o[7]}, 32'h1);
    cmd_start = 1; nxt(); cmd_stop = 1; nxt(2);
    chk("R9 stop idle", {31'd0, status_o[7]}, 32'h1);

    phase = "R10";
    cmd_start = 1; cmd_stop = 1; nxt(2);
    chk("R10 start wins", {31'd0, status_o[7]}, 32'h0);
    frame_busy = 1; cmd_stop = 1; nxt(2); cmd_start = 1; nxt(); frame_busy = 0; nxt(3);
    chk("R10 pending stop cancelled", {31'd0, status_o[7]}, 32'h0);

    phase = "R11";
    ev_ring_ovw = 1; nxt(2);
    chk("R11 overwrite sets", {24'd0, status_o & 8'h90}, 32'h90);
    frame_removed = 1; nxt(2);
    chk("R11 removal clears", {31'd0, status_o[7]}, 32'h0);
    ev_ring_ovw = 1; frame_removed = 1; cmd_start = 1; nxt(2);
    chk("R11 set beats clear", {31'd0, status_o[7]}, 32'h1);

    phase = "R5";
    hwrite(0, 8'h7F);
    tally[7:0] = 8'h7F; nxt(2);
    chk("R5 below msb", {31'd0, status_o[5]}, 32'h0);
    tally[7:0] = 8'h80; nxt(2);
    chk("R5 msb rise", {31'd0, status_o[5]}, 32'h1);
    hwrite(0, 8'h20); tally[7:0] = 8'h81; nxt(3);
    chk("R5 held msb no re-set", {31'd0, status_o[5]}, 32'h0);
    tally[15:8] = 8'h80; tally[23:16] = 8'h80; nxt(2);
    chk("R5 other counters", {31'd0, status_o[5]}, 32'h1);
    tally = '0; nxt(2);

    phase = "R7";
    for (int c = 0; c < 3000; c++) begin
      ev_rx_ok = ($urandom_range(0, 7) == 0);
      ev_tx_ok = ($urandom_range(0, 7) == 0);
      ev_rx_err = ($urandom_range(0, 15) == 0);
      ev_tx_err = ($urandom_range(0, 15) == 0);
      ev_ring_ovw = ($urandom_range(0, 31) == 0);
      ev_xfer_done = ($urandom_range(0, 7) == 0);
      cmd_start = ($urandom_range(0, 31) == 0);
      cmd_stop = ($urandom_range(0, 31) == 0);
      frame_removed = ($urandom_range(0, 15) == 0);
      if ($urandom_range(0, 7) == 0) frame_busy = ~frame_busy;
      if ($urandom_range(0, 3) == 0) tally = tally + {NT*TW{1'b0}} + 24'h010101 * $urandom_range(0, 40);
      host_we = ($urandom_range(0, 3) == 0);
      host_sel = $urandom_range(0, 1);
      host_wdata = 8'($urandom_range(0, 255));
      nxt();
    end
    nxt(3);

    done = 1;
    summary();
    $finish;
  end
endmodule